// File: doc/BRIEF.md
# Hierarchical Active-Low Row Decoder

This block turns a 5-bit row address into a 32-line select vector. Exactly one line is driven low and every other line stays high. The decode is built as a tree. A predecoder looks at the upper three address bits and drives one of eight active-low group enables. Each group enable feeds a small 2-to-4 cell, which decodes the two low address bits into four active-low rows. A global active-low enable gates the predecoder, so deasserting it silences the whole tree.

A level-sensitive phase input models a precharge/evaluate discipline. While the phase is low (precharge), every row rests at its inactive high level. While the phase is high (evaluate), only the addressed row falls. The address must be held steady through an evaluate phase.

A two-state phase tracker watches the phase input and has these states and transitions:
- States: PRECHARGE and EVALUATE.
- PRECHARGE goes to EVALUATE on START_EVAL, when the phase input is high at a clock edge.
- EVALUATE returns to PRECHARGE on END_EVAL, when the phase input is low at a clock edge.
- EVALUATE stays in EVALUATE on HOLD_EVAL.
- PRECHARGE stays in PRECHARGE on HOLD_PRE.

At every evaluate edge a shadow register samples the decoded vector. On END_EVAL the shadow is copied to a registered output, which keeps the last evaluated row select stable across the following precharge.

Top module: `hier_row_decoder`

## Requirements
- R1: With the enable low and the phase high, row_n bit i is low exactly when addr equals i. Bits are numbered so that bit index = addr[4:2]*4 + addr[1:0].
- R2: With the enable low and the phase high, exactly one bit of row_n is low.
- R3: With en_n high, row_n is all ones in both phases. An evaluate phase taken with en_n high leaves row_q_n all ones after its END_EVAL.
- R4: With the phase low (precharge), row_n is all ones for every address and enable value.
- R5: While rst_n is low and after it is released with the phase low, row_q_n is all ones.
- R6: On the first clock edge where the phase is low after one or more edges with it high, row_q_n takes the row_n value present at the last of those high edges. It shows that value from that edge on.
- R7: row_q_n changes at no clock edge other than an END_EVAL edge. It holds during precharge address changes and during a later evaluate phase, until that phase ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the phase tracker and the captured output |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Global active-low decoder enable |
| addr | input | 5 | Row address |
| eval | input | 1 | Phase level: 1 = evaluate, 0 = precharge |
| row_n | output | 32 | Combinational active-low row select |
| row_q_n | output | 32 | Row select captured at the end of each evaluate phase |

## Verification
The hardest condition to reach from the ports is the END_EVAL edge itself. There, the live vector has already returned to all ones while the captured output must still receive the vector from the preceding evaluate edge. A bug that samples the live vector at the wrong edge therefore produces all ones, and that looks like a plausible idle value. The stimulus opens evaluate phases of varying length on distinct addresses and then drops the phase. It checks row_q_n both at the edge just before END_EVAL, where the old value must persist, and just after END_EVAL, where the new one must appear. It also runs an evaluate phase with the enable high, so that a capture of all ones is distinguished from a missed capture.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_EVALUATE  = 1'b1
    } phase_e;

    localparam int unsigned CELL_IN_W  = 2;
    localparam int unsigned CELL_OUT_N = 4;
endpackage

// File: rtl/hrd_cell_2to4.sv
// Active-low enabled 2-to-4 cell with active-low outputs.
module hrd_cell_2to4
    import hrd_pkg::*;
(
    input  logic                  en_n,
    input  logic [CELL_IN_W-1:0]  a,
    output logic [CELL_OUT_N-1:0] y_n
);
    logic on;
    assign on = ~en_n;

    always_comb begin
        y_n[0] = ~(on & ~a[1] & ~a[0]);
        y_n[1] = ~(on & ~a[1] &  a[0]);
        y_n[2] = ~(on &  a[1] & ~a[0]);
        y_n[3] = ~(on &  a[1] &  a[0]);
    end
endmodule

// File: rtl/hrd_predec.sv
// Upper-bit predecoder: one active-low group enable per sub-decoder.
module hrd_predec #(
    parameter int unsigned SEL_W = 3,
    localparam int unsigned GROUPS = 1 << SEL_W
) (
    input  logic              gate_n,
    input  logic [SEL_W-1:0]  sel,
    output logic [GROUPS-1:0] grp_en_n
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_en_n[g] = ~(~gate_n && (sel == SEL_W'(g)));
    end
endmodule

// File: rtl/hrd_capture.sv
// Phase tracker and end-of-evaluate capture register.
module hrd_capture
    import hrd_pkg::*;
#(
    parameter int unsigned ROWS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eval,
    input  logic [ROWS-1:0] live_n,
    output logic [ROWS-1:0] held_n
);
    phase_e          state_q, state_d;
    logic            end_eval;
    logic [ROWS-1:0] shadow_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_PRECHARGE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        end_eval = 1'b0;
        unique case (state_q)
            PH_PRECHARGE: begin
                if (eval) state_d = PH_EVALUATE;      // START_EVAL
            end
            PH_EVALUATE: begin
                if (!eval) begin                      // END_EVAL
                    state_d  = PH_PRECHARGE;
                    end_eval = 1'b1;
                end
            end
            default: state_d = PH_PRECHARGE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '1;
            held_n   <= '1;
        end else begin
            if (eval)     shadow_q <= live_n;
            if (end_eval) held_n   <= shadow_q;
        end
    end
endmodule

// File: rtl/hier_row_decoder.sv
module hier_row_decoder
    import hrd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter bit          USE_REG = 1'b1,
    localparam int unsigned HI_W   = ADDR_W - CELL_IN_W,
    localparam int unsigned GROUPS = 1 << HI_W,
    localparam int unsigned ROWS   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              eval,
    output logic [ROWS-1:0]   row_n,
    output logic [ROWS-1:0]   row_q_n
);
    logic              tree_gate_n;
    logic [GROUPS-1:0] grp_en_n;

    // Precharge acts as a second active-low disable on the tree.
    assign tree_gate_n = en_n | ~eval;

    hrd_predec #(.SEL_W(HI_W)) u_predec (
        .gate_n   (tree_gate_n),
        .sel      (addr[ADDR_W-1:CELL_IN_W]),
        .grp_en_n (grp_en_n)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_cell
        hrd_cell_2to4 u_cell (
            .en_n (grp_en_n[g]),
            .a    (addr[CELL_IN_W-1:0]),
            .y_n  (row_n[g*CELL_OUT_N +: CELL_OUT_N])
        );
    end

    if (USE_REG) begin : g_reg
        hrd_capture #(.ROWS(ROWS)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .eval   (eval),
            .live_n (row_n),
            .held_n (row_q_n)
        );
    end else begin : g_noreg
        assign row_q_n = row_n;
    end
endmodule

// File: rtl/hier_row_decoder_chk.sv
module hier_row_decoder_chk #(
    parameter int unsigned ADDR_W  = 5,
    parameter bit          USE_REG = 1'b1,
    localparam int unsigned ROWS   = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic [ADDR_W-1:0] addr,
    input logic              eval,
    input logic [ROWS-1:0]   row_n,
    input logic [ROWS-1:0]   row_q_n
);
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |-> row_n == '1); // R4

    AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> row_n == '1); // R3

    AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !en_n) |-> $countones(~row_n) == 1); // R2

    AST_ADDR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !en_n) |-> !row_n[addr]); // R1

    if (USE_REG) begin : g_reg_chk
        AST_HOLD_Q: assert property (@(posedge clk) disable iff (!rst_n)
            eval |=> $stable(row_q_n)); // R7

        AST_CAPTURE_Q: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(eval) && !eval) |=> row_q_n == $past(row_n, 2)); // R6
    end
endmodule

bind hier_row_decoder hier_row_decoder_chk #(.ADDR_W(ADDR_W), .USE_REG(USE_REG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_n    (en_n),
    .addr    (addr),
    .eval    (eval),
    .row_n   (row_n),
    .row_q_n (row_q_n)
);

// File: tb/test_hier_row_decoder.sv
`timescale 1ns/1ps
module test_hier_row_decoder;
    localparam int AW = 5;
    localparam int NR = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          eval = 1'b0;
    logic [NR-1:0] row_n, row_q_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    hier_row_decoder i_hier_row_decoder (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .addr(addr),
        .eval(eval), .row_n(row_n), .row_q_n(row_q_n)
    );

    typedef struct packed {
        logic [4:0] a;
        logic       dis;
        logic       ev;
        logic [5:0] idx; // 32 means no row active
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{5'd0,  1'b0, 1'b1, 6'd0},
        '{5'd31, 1'b0, 1'b1, 6'd31},
        '{5'd5,  1'b0, 1'b1, 6'd5},
        '{5'd18, 1'b0, 1'b1, 6'd18},
        '{5'd18, 1'b0, 1'b0, 6'd32},
        '{5'd18, 1'b1, 1'b1, 6'd32},
        '{5'd7,  1'b1, 1'b0, 6'd32},
        '{5'd12, 1'b0, 1'b1, 6'd12},
        '{5'd13, 1'b0, 1'b1, 6'd13},
        '{5'd27, 1'b0, 1'b1, 6'd27}
    };

    function automatic logic [NR-1:0] exp_vec(input int idx);
        logic [NR-1:0] v;
        v = '1;
        if (idx < NR) v[idx] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string rid, input logic [NR-1:0] act, input logic [NR-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rid, act, exp);
        end
    endtask

    // Evaluate phase of 'len' edges on address a, then END_EVAL; checks R6/R7.
    task automatic run_cap(input logic [AW-1:0] a, input logic dis, input int len,
                           input logic [NR-1:0] prev, input logic [NR-1:0] want);
        @(negedge clk);
        addr = a; en_n = dis; eval = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            #1 chk("R7", row_q_n, prev);
        end
        eval = 1'b0;
        @(negedge clk);
        #1 chk("R6", row_q_n, want);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R5", row_q_n, '1);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R5", row_q_n, '1);
        chk("R4", row_n, '1);

        // Table walk: combinational decode
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr = TBL[i].a; en_n = TBL[i].dis; eval = TBL[i].ev;
            #1 chk(TBL[i].idx == 6'd32 ? "R3/R4" : "R1", row_n, exp_vec(int'(TBL[i].idx)));
        end
        @(negedge clk);
        eval = 1'b0;
        @(negedge clk);

        // Every address, enable on/off, both phases
        for (int a = 0; a < NR; a++) begin
            @(negedge clk);
            addr = AW'(a); en_n = 1'b0; eval = 1'b1;
            #1 chk("R1", row_n, exp_vec(a));
            total++;
            if ($countones(~row_n) != 1) begin
                bad++;
                $display("FAIL R2 act=%0d exp=1", $countones(~row_n));
            end
            @(negedge clk);
            en_n = 1'b1;
            #1 chk("R3", row_n, '1);
            @(negedge clk);
            eval = 1'b0;
            #1 chk("R3", row_n, '1);
            @(negedge clk);
            en_n = 1'b0;
            #1 chk("R4", row_n, '1);
        end
        @(negedge clk);

        // Capture sequences; previous captured value is whatever ended last (all ones
        // after the loop above, whose last evaluate phase was disabled).
        run_cap(5'd9,  1'b0, 1, '1,         exp_vec(9));
        run_cap(5'd22, 1'b0, 3, exp_vec(9),  exp_vec(22));
        run_cap(5'd3,  1'b1, 2, exp_vec(22), '1);
        run_cap(5'd30, 1'b0, 4, '1,          exp_vec(30));

        // Precharge address changes must not disturb row_q_n
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            addr = AW'(k * 7); en_n = 1'(k & 1);
            #1 chk("R7", row_q_n, exp_vec(30));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule